// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Non-Blocking Cache

This block keeps a small file of cache misses that are waiting for memory, so that the cache can keep serving hits, and accept further misses, while earlier fetches are still in flight. Each incoming miss carries a block address and a requester tag. The block answers in the same cycle with exactly one outcome.

- **Primary miss:** no entry holds the block, so a new entry is taken and a memory fetch is issued.
- **Secondary miss:** the block is already in flight, so the tag joins the existing entry and no fetch is issued.
- **Stall:** no room in the file or in the entry.
- **Hit:** the block's data is returning in that very cycle.

When memory answers with a block address, the matching entry is freed. The requester tags merged into that entry are then played out one per cycle, in the order they arrived, so that the cache can wake each waiting requester. Cache hits never pass through this block and are never held up by it. The data array and any memory timing beyond the request and response handshake live elsewhere.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is held: `rsp_ready` is 1, `wake_valid` is 0, and with `miss_valid` low none of the four outcome outputs is asserted.
- R2: A miss whose block matches no held entry, while a free entry exists, asserts `res_primary`. In the same cycle it raises `mem_req_valid` with `mem_req_addr` equal to the miss block, and it occupies one entry. The outcome outputs use the bit order {primary, secondary, stall, hit}.
- R3: A miss whose block matches a held entry that holds fewer than 4 tags asserts `res_secondary`, leaves `mem_req_valid` low and appends its tag to that entry.
- R4: A miss to a held block whose entry already holds 4 tags asserts `res_stall`, issues nothing and changes no entry.
- R5: A miss to a new block while all 16 entries are held asserts `res_stall`, issues nothing and changes no entry.
- R6: A response is accepted when `rsp_valid` and `rsp_ready` are both high and `rsp_addr` matches a held entry. The entry is then freed, so that a later miss to the same block is primary again.
- R7: Starting the cycle after an accepted response, `wake_valid` is high for as many cycles as the entry held tags. `wake_tag` gives them in arrival order, and `wake_last` marks the final one.
- R8: A miss and an accepted response for the same block in the same cycle give `res_hit`, with no fetch and no allocation. The miss tag does not appear among the released tags.
- R9: A response whose address matches no held entry has no effect: no tag is released and no entry is freed.
- R10: `rsp_ready` is low while more than one released tag is still to be played out, and high otherwise.
- R11: Every cycle with `miss_valid` high gives exactly one of the four outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | A cache miss is presented |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_tag | input | TAG_W | Requester tag of the miss |
| res_primary | output | 1 | New entry taken, fetch issued |
| res_secondary | output | 1 | Merged into an in-flight entry |
| res_stall | output | 1 | Miss refused, retry later |
| res_hit | output | 1 | Block returns this cycle, serve as hit |
| mem_req_valid | output | 1 | Memory fetch request |
| mem_req_addr | output | ADDR_W | Block address to fetch |
| rsp_valid | input | 1 | Memory returns a block |
| rsp_addr | input | ADDR_W | Block address of the returned data |
| rsp_ready | output | 1 | Block can accept a response |
| wake_valid | output | 1 | A released requester tag is presented |
| wake_tag | output | TAG_W | Released requester tag |
| wake_last | output | 1 | Final tag of the released entry |

## Verification
The outcome of a miss, the fetch request and `rsp_ready` are combinational, so they are due in the same cycle as the stimulus. The bench drives on the falling edge and reads them one time unit later, before the rising edge commits anything. Released tags are registered: the first appears one rising edge after the accepted response and each following one an edge later. The bench therefore reads them at successive falling edges and checks that `wake_valid` is low at the falling edge after the last tag. Effects on entry state, such as a freed or an unchanged entry, are observed through the outcome of a later miss.

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  parameter int TAG_W   = 6,
  parameter int MERGE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TAG_W-1:0]  miss_tag,
  output logic              res_primary,
  output logic              res_secondary,
  output logic              res_stall,
  output logic              res_hit,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_ready,
  output logic              wake_valid,
  output logic [TAG_W-1:0]  wake_tag,
  output logic              wake_last
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(MERGE + 1);
  localparam int SLOT_W = (MERGE > 1) ? $clog2(MERGE) : 1;

  logic [ENTRIES-1:0] busy;
  logic [ADDR_W-1:0]  blk   [ENTRIES];
  logic [CNT_W-1:0]   fill  [ENTRIES];
  logic [TAG_W-1:0]   tags  [ENTRIES][MERGE];
  logic [TAG_W-1:0]   drain [MERGE];
  logic [CNT_W-1:0]   left;

  logic             m_hit, r_hit, has_free, rsp_fire;
  logic [IDX_W-1:0] m_idx, r_idx, f_idx;

  always_comb begin
    m_hit = 1'b0; m_idx = '0;
    r_hit = 1'b0; r_idx = '0;
    has_free = 1'b0; f_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (busy[i] && blk[i] == miss_addr) begin m_hit = 1'b1; m_idx = IDX_W'(i); end
      if (busy[i] && blk[i] == rsp_addr)  begin r_hit = 1'b1; r_idx = IDX_W'(i); end
    end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!busy[i]) begin has_free = 1'b1; f_idx = IDX_W'(i); end
  end

  assign rsp_ready     = left <= CNT_W'(1);
  assign rsp_fire      = rsp_valid && rsp_ready && r_hit;
  assign res_hit       = miss_valid && rsp_fire && rsp_addr == miss_addr;
  assign res_secondary = miss_valid && !res_hit && m_hit && fill[m_idx] != CNT_W'(MERGE);
  assign res_primary   = miss_valid && !res_hit && !m_hit && has_free;
  assign res_stall     = miss_valid && !res_hit && !res_secondary && !res_primary;
  assign mem_req_valid = res_primary;
  assign mem_req_addr  = miss_addr;
  assign wake_valid    = left != '0;
  assign wake_tag      = drain[0];
  assign wake_last     = left == CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      left <= '0;
    end else begin
      if (rsp_fire) busy[r_idx] <= 1'b0;
      if (res_primary) begin
        busy[f_idx]    <= 1'b1;
        blk[f_idx]     <= miss_addr;
        fill[f_idx]    <= CNT_W'(1);
        tags[f_idx][0] <= miss_tag;
      end
      if (res_secondary) begin
        tags[m_idx][fill[m_idx][SLOT_W-1:0]] <= miss_tag;
        fill[m_idx] <= fill[m_idx] + 1'b1;
      end
      if (rsp_fire) begin
        for (int k = 0; k < MERGE; k++) drain[k] <= tags[r_idx][k];
        left <= fill[r_idx];
      end else if (left != '0) begin
        for (int k = 0; k < MERGE - 1; k++) drain[k] <= drain[k + 1];
        left <= left - 1'b1;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> $countones({res_primary, res_secondary, res_stall, res_hit}) == 1); // R11
  AST_PRIMARY_TAKES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    res_primary && !rsp_fire |=> $countones(busy) == $past($countones(busy)) + 1); // R2
  AST_STALL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    res_stall && !rsp_fire |=> $stable(busy)); // R5
  AST_RELEASE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> wake_valid); // R7
  AST_BUSY_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> wake_valid && !wake_last); // R10
  AST_NO_FETCH_ON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_secondary || res_hit) |=> $countones(busy) <= $past($countones(busy))); // R3
endmodule

// File: tb/tb_mshr_file.sv
module tb_mshr_file;
  localparam int CLK_PERIOD = 10;
  localparam int E  = 16;
  localparam int AW = 26;
  localparam int TW = 6;
  localparam int M  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, rsp_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0, rsp_addr = '0;
  logic [TW-1:0] miss_tag = '0;
  logic res_primary, res_secondary, res_stall, res_hit;
  logic mem_req_valid, rsp_ready, wake_valid, wake_last;
  logic [AW-1:0] mem_req_addr;
  logic [TW-1:0] wake_tag;

  int n_cmp = 0, n_bad = 0;

  mshr_file #(.ENTRIES(E), .ADDR_W(AW), .TAG_W(TW), .MERGE(M)) dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_tag(miss_tag), .res_primary(res_primary), .res_secondary(res_secondary),
    .res_stall(res_stall), .res_hit(res_hit), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_ready(rsp_ready), .wake_valid(wake_valid), .wake_tag(wake_tag),
    .wake_last(wake_last));

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam int PRI = 8, SEC = 4, STL = 2, HIT = 1;

  task automatic chk(input string r, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] blk(input int i);
    return AW'(32'h100 + i * 3);
  endfunction

  function automatic logic [TW-1:0] tg(input int i, input int j);
    return TW'((i * M + j) % 64);
  endfunction

  task automatic miss(input logic [AW-1:0] a, input logic [TW-1:0] t, input int exp, input string r);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a; miss_tag = t;
    #1;
    chk(r, {res_primary, res_secondary, res_stall, res_hit}, exp);
    chk(r, mem_req_valid, exp == PRI);
    if (exp == PRI) chk(r, mem_req_addr, a);
    @(posedge clk); #1;
    miss_valid = 1'b0;
  endtask

  task automatic rel(input logic [AW-1:0] a, input int n,
                     input logic [TW-1:0] t0, t1, t2, t3, input string r);
    logic [TW-1:0] ex [4];
    ex[0] = t0; ex[1] = t1; ex[2] = t2; ex[3] = t3;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_addr = a;
    #1 chk({r, " R6 ready"}, rsp_ready, 1);
    @(posedge clk); #1;
    rsp_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({r, " R7 valid"}, wake_valid, 1);
      chk({r, " R7 tag"}, wake_tag, ex[k]);
      chk({r, " R7 last"}, wake_last, k == n - 1);
      chk({r, " R10 ready"}, rsp_ready, (n - k) <= 1);
    end
    @(negedge clk);
    chk({r, " R7 end"}, wake_valid, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", rsp_ready, 1);
    chk("R1 wake", wake_valid, 0);
    chk("R1 outcome", {res_primary, res_secondary, res_stall, res_hit}, 0);

    for (int i = 0; i < E; i++) miss(blk(i), tg(i, 0), PRI, "R2 primary");
    for (int i = 0; i < E; i++)
      for (int j = 1; j < M; j++) miss(blk(i), tg(i, j), SEC, "R3 merge");
    for (int i = 0; i < E; i++) miss(blk(i), 6'h3f, STL, "R4 entry full");
    miss(AW'(32'h3999), 6'h3f, STL, "R5 file full");

    @(negedge clk);
    rsp_valid = 1'b1; rsp_addr = AW'(32'h3777);
    @(posedge clk); #1 rsp_valid = 1'b0;
    @(negedge clk);
    chk("R9 no wake", wake_valid, 0);
    miss(AW'(32'h3999), 6'h3f, STL, "R9 nothing freed");

    rel(blk(0), 4, tg(0,0), tg(0,1), tg(0,2), tg(0,3), "entry0");
    miss(blk(0), 6'h2a, PRI, "R6 reuse");
    miss(AW'(32'h3999), 6'h3f, STL, "R5 full again");

    @(negedge clk);
    miss_valid = 1'b1; miss_addr = blk(1); miss_tag = 6'h15;
    rsp_valid = 1'b1; rsp_addr = blk(1);
    #1;
    chk("R8 outcome", {res_primary, res_secondary, res_stall, res_hit}, HIT);
    chk("R8 no fetch", mem_req_valid, 0);
    @(posedge clk); #1;
    miss_valid = 1'b0; rsp_valid = 1'b0;
    for (int k = 0; k < M; k++) begin
      @(negedge clk);
      chk("R8 wake tag", wake_tag, tg(1, k));
      chk("R8 wake valid", wake_valid, 1);
    end
    @(negedge clk);
    chk("R8 tag not merged", wake_valid, 0);
    miss(blk(1), 6'h16, PRI, "R8 no allocation");

    for (int i = 2; i < E; i++)
      rel(blk(i), 4, tg(i,0), tg(i,1), tg(i,2), tg(i,3), "sweep");
    rel(blk(0), 1, 6'h2a, 0, 0, 0, "entry0 single");
    rel(blk(1), 1, 6'h16, 0, 0, 0, "entry1 single");
    miss(blk(5), 6'h01, PRI, "R6 empty again");
    miss(blk(5), 6'h02, SEC, "R3 after reuse");
    rel(blk(5), 2, 6'h01, 6'h02, 0, 0, "final");
    finish_run();
  end
endmodule